// File: doc/BRIEF.md
# Bidirectional Buffer Port Access Decoder

This block is the control front end of one side of a two-direction buffer. Its port has an 18-bit data bus, an active-low chip select, a read/write select, an active-low strobe enable, an active-low output enable and a three-bit address. The block decodes these pins into one of several targets:

- the outgoing FIFO (writes) and the incoming FIFO (reads);
- a bypass word that skips both FIFOs;
- four threshold offset registers that the flag logic of the two FIFO cores reads.

The FIFO storage and the flag generation sit outside. The three-state pad is represented by a data-out bus and a separate drive-enable.

Writes pass through an input register. A word captured on one clock edge is acted on in the following cycle. For the outgoing FIFO, the word is offered on a valid/ready push stream.

Reads pop the incoming FIFO through a valid/ready stream. The block raises ready only while a FIFO read strobe is present on the port pins. A word moves on a clock edge where ready and valid are both high, and lands in the output register.

Back-pressure rules:
- A push offer lasts exactly one cycle and is never held. If ready is low in that cycle, the word is dropped, so writing to a full FIFO does nothing.
- A pop with valid low moves nothing, and the output register keeps its value.

Top module: `bififo_port_access`

## Requirements
- R1: While `cs_n` is 1, the port does nothing, whatever `rw`, `en_n`, `addr` and `din` are. No push is offered, `pop_ready` stays 0, `drv_en` stays 0, and no offset register or bypass word changes.
- R2: A write strobe (`cs_n`=0, `rw`=0, `en_n`=0) with `addr`=000 raises `push_valid` for exactly one cycle, starting in the cycle after the capturing edge, with `push_data` equal to the captured `din`.
- R3: A read strobe (`cs_n`=0, `rw`=1, `en_n`=0) with `addr`=000 holds `pop_ready` at 1 in that cycle. If `pop_valid` is 1 at the edge, `dout` shows `pop_data` after that edge.
- R4: Overflow and underflow are suppressed. A push offer seen with `push_ready`=0 is not repeated in the next cycle, and a pop with `pop_valid`=0 leaves `dout` unchanged.
- R5: Address 001 selects the bypass word. A write updates `byp_out` one cycle after the capturing edge. A read loads `byp_in` into the output register.
- R6: Addresses 100, 101, 110 and 111 write, in that order, the outgoing almost-empty offset, the outgoing almost-full offset, the incoming almost-empty offset and the incoming almost-full offset. Only `din[8:0]` is stored; `din[17:9]` is ignored. The new value shows one cycle after the capturing edge.
- R7: After reset, all four offsets read 8, `dout` is 0, `byp_out` is 0 and `push_valid` is 0.
- R8: A read of an offset address loads the stored 9-bit value into `dout[8:0]`, with `dout[17:9]` zero.
- R9: Addresses 010 and 011 are reserved. A write to them changes nothing and pushes nothing. A read from them loads zero into the output register.
- R10: `drv_en` is 1 exactly while `cs_n`=0, `rw`=1 and `oe_n`=0, with no clock delay. `dout` always shows the output register.
- R11: With `en_n`=1, neither a write nor a read takes place: no push offer, `pop_ready` 0, output register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Access strobe enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| addr | input | 3 | Target select |
| din | input | 18 | Write data from the pad |
| dout | output | 18 | Output register toward the pad |
| drv_en | output | 1 | Pad drive enable |
| push_valid | output | 1 | Push offer to the outgoing FIFO core |
| push_ready | input | 1 | Outgoing FIFO not full |
| push_data | output | 18 | Word offered to the outgoing FIFO |
| pop_valid | input | 1 | Incoming FIFO not empty |
| pop_ready | output | 1 | Pop request to the incoming FIFO |
| pop_data | input | 18 | Head word of the incoming FIFO |
| byp_out | output | 18 | Bypass word toward the far side |
| byp_in | input | 18 | Bypass word from the far side |
| ofs_out_ae | output | 9 | Outgoing FIFO almost-empty offset |
| ofs_out_af | output | 9 | Outgoing FIFO almost-full offset |
| ofs_in_ae | output | 9 | Incoming FIFO almost-empty offset |
| ofs_in_af | output | 9 | Incoming FIFO almost-full offset |

## Verification
The assertions watch the cycle-level rules on every clock:
- deselect forces both strobes and the pad drive low, and leaves the offsets unchanged;
- every push offer traces back to a FIFO write strobe one edge earlier and carries that edge's data;
- a completed pop puts the popped word on `dout`, and an empty pop leaves `dout` stable.

The directed scenarios cover what a single-cycle property cannot see:
- the address map of the four offsets and their reset value of 8;
- masking of the upper nine bits on offset writes, and zero extension on offset reads;
- the round trip of the bypass word;
- the silence of the reserved addresses.

// File: rtl/bififo_port_pkg.sv
package bififo_port_pkg;

  // Target kinds after address decode
  typedef enum logic [1:0] {
    SEL_FIFO = 2'd0,
    SEL_BYP  = 2'd1,
    SEL_RSVD = 2'd2,
    SEL_OFS  = 2'd3
  } sel_e;

  localparam int NUM_OFS = 4;
  localparam int IDX_W   = $clog2(NUM_OFS);

  // addr[2] picks the offset bank; below that, 000 is the FIFO pair,
  // 001 the bypass word, 010/011 are reserved.
  function automatic sel_e decode_addr(input logic [2:0] a);
    sel_e s;
    if (a[2])               s = SEL_OFS;
    else if (a[1])          s = SEL_RSVD;
    else if (a[0])          s = SEL_BYP;
    else                    s = SEL_FIFO;
    return s;
  endfunction

endpackage

// File: rtl/bpa_decode.sv
module bpa_decode
  import bififo_port_pkg::*;
(
  input  logic             cs_n,
  input  logic             rw,
  input  logic             en_n,
  input  logic [2:0]       addr,
  output logic             wr_req,
  output logic             rd_req,
  output sel_e             sel,
  output logic [IDX_W-1:0] idx
);

  logic active;

  always_comb begin
    active = !cs_n && !en_n;
    wr_req = active && !rw;
    rd_req = active && rw;
    sel    = decode_addr(addr);
    idx    = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/bpa_offset_bank.sv
module bpa_offset_bank
  import bififo_port_pkg::*;
#(
  parameter int OFS_W   = 9,
  parameter int RST_VAL = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [IDX_W-1:0]                widx,
  input  logic [OFS_W-1:0]                wdata,
  output logic [NUM_OFS-1:0][OFS_W-1:0]   ofs_q
);

  localparam logic [OFS_W-1:0] RST_Q = OFS_W'(RST_VAL);

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    logic hit;
    assign hit = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ofs_q[g] <= RST_Q;
      else if (hit) ofs_q[g] <= wdata;
    end
  end

endmodule

// File: rtl/bpa_read_path.sv
module bpa_read_path
  import bififo_port_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_req,
  input  sel_e                          sel,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          pop_valid,
  input  logic [DATA_W-1:0]             pop_data,
  input  logic [DATA_W-1:0]             byp_in,
  input  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q,
  output logic [DATA_W-1:0]             out_q
);

  logic              load;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    load = 1'b0;
    nxt  = out_q;
    if (rd_req) begin
      unique case (sel)
        SEL_FIFO: begin
          load = pop_valid;          // empty pop leaves the register alone
          nxt  = pop_data;
        end
        SEL_BYP: begin
          load = 1'b1;
          nxt  = byp_in;
        end
        SEL_OFS: begin
          load = 1'b1;
          nxt  = DATA_W'(ofs_q[idx]); // zero-extended
        end
        default: begin
          load = 1'b1;
          nxt  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (load) out_q <= nxt;
  end

endmodule

// File: rtl/bififo_port_access.sv
module bififo_port_access
  import bififo_port_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFS_W   = 9,
  parameter int OFS_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              en_n,
  input  logic              oe_n,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              drv_en,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [DATA_W-1:0] push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] byp_out,
  input  logic [DATA_W-1:0] byp_in,
  output logic [OFS_W-1:0]  ofs_out_ae,
  output logic [OFS_W-1:0]  ofs_out_af,
  output logic [OFS_W-1:0]  ofs_in_ae,
  output logic [OFS_W-1:0]  ofs_in_af
);

  logic             wr_req, rd_req;
  sel_e             sel;
  logic [IDX_W-1:0] idx;

  // Input register stage
  logic              wr_pend;
  sel_e              wr_sel;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q;
  logic [DATA_W-1:0]             byp_q;
  logic [DATA_W-1:0]             out_q;

  bpa_decode u_dec (
    .cs_n   (cs_n),
    .rw     (rw),
    .en_n   (en_n),
    .addr   (addr),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .sel    (sel),
    .idx    (idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      wr_sel  <= SEL_RSVD;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_pend <= wr_req;
      if (wr_req) begin
        wr_sel  <= sel;
        wr_idx  <= idx;
        wr_data <= din;
      end
    end
  end

  // Outgoing FIFO push: one-cycle offer, dropped if the core is full
  assign push_valid = wr_pend && (wr_sel == SEL_FIFO);
  assign push_data  = wr_data;

  // Bypass word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            byp_q <= '0;
    else if (wr_pend && wr_sel == SEL_BYP) byp_q <= wr_data;
  end
  assign byp_out = byp_q;

  bpa_offset_bank #(
    .OFS_W   (OFS_W),
    .RST_VAL (OFS_RST)
  ) u_ofs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_pend && wr_sel == SEL_OFS),
    .widx  (wr_idx),
    .wdata (wr_data[OFS_W-1:0]),
    .ofs_q (ofs_q)
  );

  assign ofs_out_ae = ofs_q[0];
  assign ofs_out_af = ofs_q[1];
  assign ofs_in_ae  = ofs_q[2];
  assign ofs_in_af  = ofs_q[3];

  // Incoming FIFO pop request straight from the strobe
  assign pop_ready = rd_req && (sel == SEL_FIFO);

  bpa_read_path #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .sel       (sel),
    .idx       (idx),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .byp_in    (byp_in),
    .ofs_q     (ofs_q),
    .out_q     (out_q)
  );

  assign dout   = out_q;
  assign drv_en = !cs_n && rw && !oe_n;

endmodule

// File: rtl/bififo_port_access_chk.sv
module bififo_port_access_chk #(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rw,
  input logic              en_n,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              drv_en,
  input logic              push_valid,
  input logic [DATA_W-1:0] push_data,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic [DATA_W-1:0] pop_data,
  input logic [OFS_W-1:0]  ofs_out_ae,
  input logic [OFS_W-1:0]  ofs_out_af,
  input logic [OFS_W-1:0]  ofs_in_ae,
  input logic [OFS_W-1:0]  ofs_in_af
);

  logic [4*OFS_W-1:0] ofs_all;
  assign ofs_all = {ofs_out_ae, ofs_out_af, ofs_in_ae, ofs_in_af};

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!pop_ready && !drv_en)); // R1

  AST_DESELECT_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> $stable(ofs_all)); // R1

  AST_PUSH_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(!cs_n && !rw && !en_n && addr == 3'b000)); // R2

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (push_data == $past(din))); // R2

  AST_POP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && pop_valid) |=> (dout == $past(pop_data))); // R3

  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |=> $stable(dout)); // R4

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (!cs_n && rw)); // R10

endmodule

bind bififo_port_access bififo_port_access_chk #(
  .DATA_W (DATA_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .rw         (rw),
  .en_n       (en_n),
  .addr       (addr),
  .din        (din),
  .dout       (dout),
  .drv_en     (drv_en),
  .push_valid (push_valid),
  .push_data  (push_data),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .pop_data   (pop_data),
  .ofs_out_ae (ofs_out_ae),
  .ofs_out_af (ofs_out_af),
  .ofs_in_ae  (ofs_in_ae),
  .ofs_in_af  (ofs_in_af)
);

// File: tb/bififo_port_access_tb.sv
module bififo_port_access_tb;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cs_n = 1'b1, rw = 1'b0, en_n = 1'b1, oe_n = 1'b1;
  logic [2:0]        addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              drv_en;
  logic              push_valid;
  logic              push_ready = 1'b1;
  logic [DATA_W-1:0] push_data;
  logic              pop_valid = 1'b0;
  logic              pop_ready;
  logic [DATA_W-1:0] pop_data = '0;
  logic [DATA_W-1:0] byp_out;
  logic [DATA_W-1:0] byp_in = '0;
  logic [OFS_W-1:0]  ofs_out_ae, ofs_out_af, ofs_in_ae, ofs_in_af;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bififo_port_access u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .en_n(en_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .drv_en(drv_en),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .byp_out(byp_out), .byp_in(byp_in),
    .ofs_out_ae(ofs_out_ae), .ofs_out_af(ofs_out_af),
    .ofs_in_ae(ofs_in_ae), .ofs_in_af(ofs_in_af)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; rw = 1'b0; en_n = 1'b1; addr = '0; din = '0;
  endtask

  // Strobe one write; returns at the negedge after the capturing edge
  task automatic do_write(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; en_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; en_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk);
    idle();
  endtask

  task automatic test_reset();
    check(ofs_out_ae == 9'd8, "R7 ofs_out_ae", 32'(ofs_out_ae), 32'd8);
    check(ofs_out_af == 9'd8, "R7 ofs_out_af", 32'(ofs_out_af), 32'd8);
    check(ofs_in_ae  == 9'd8, "R7 ofs_in_ae",  32'(ofs_in_ae),  32'd8);
    check(ofs_in_af  == 9'd8, "R7 ofs_in_af",  32'(ofs_in_af),  32'd8);
    check(dout == '0, "R7 dout", 32'(dout), 32'd0);
    check(byp_out == '0, "R7 byp_out", 32'(byp_out), 32'd0);
    check(!push_valid, "R7 push_valid", 32'(push_valid), 32'd0);
  endtask

  task automatic test_fifo_write();
    push_ready = 1'b1;
    do_write(3'b000, 18'h2A5A5);
    check(push_valid, "R2 valid", 32'(push_valid), 32'd1);
    check(push_data == 18'h2A5A5, "R2 data", 32'(push_data), 32'h2A5A5);
    @(negedge clk);
    check(!push_valid, "R2 one cycle", 32'(push_valid), 32'd0);
    do_write(3'b000, 18'h00001);
    check(push_valid && push_data == 18'h00001, "R2 second word",
          32'(push_data), 32'h1);
  endtask

  task automatic test_full_drop();
    push_ready = 1'b0;
    do_write(3'b000, 18'h3C3C3);
    check(push_valid, "R4 offer while full", 32'(push_valid), 32'd1);
    @(negedge clk);
    check(!push_valid, "R4 no retry", 32'(push_valid), 32'd0);
    push_ready = 1'b1;
  endtask

  task automatic test_fifo_read();
    pop_valid = 1'b1; pop_data = 18'h13579;
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1; en_n = 1'b0; oe_n = 1'b0; addr = 3'b000;
    #1;
    check(pop_ready, "R3 pop_ready", 32'(pop_ready), 32'd1);
    check(drv_en, "R10 drive on", 32'(drv_en), 32'd1);
    oe_n = 1'b1;
    #1;
    check(!drv_en, "R10 drive off by oe_n", 32'(drv_en), 32'd0);
    oe_n = 1'b0;
    @(negedge clk);
    idle();
    pop_valid = 1'b0;
    check(dout == 18'h13579, "R3 popped word", 32'(dout), 32'h13579);
  endtask

  task automatic test_empty_read();
    pop_valid = 1'b0; pop_data = 18'h0BEEF;
    do_read(3'b000);
    check(dout == 18'h13579, "R4 empty pop holds dout", 32'(dout), 32'h13579);
  endtask

  task automatic test_offsets();
    do_write(3'b100, 18'h3FE05);
    do_write(3'b101, 18'h001F0);
    do_write(3'b110, 18'h2A1AB);
    do_write(3'b111, 18'h00100);
    @(negedge clk);
    check(ofs_out_ae == 9'h005, "R6 out_ae masked", 32'(ofs_out_ae), 32'h005);
    check(ofs_out_af == 9'h1F0, "R6 out_af", 32'(ofs_out_af), 32'h1F0);
    check(ofs_in_ae  == 9'h1AB, "R6 in_ae",  32'(ofs_in_ae),  32'h1AB);
    check(ofs_in_af  == 9'h100, "R6 in_af",  32'(ofs_in_af),  32'h100);
    do_read(3'b110);
    check(dout == 18'h001AB, "R8 read in_ae", 32'(dout), 32'h001AB);
    do_read(3'b100);
    check(dout == 18'h00005, "R8 read out_ae", 32'(dout), 32'h00005);
  endtask

  task automatic test_bypass();
    do_write(3'b001, 18'h2BEEF);
    check(!push_valid, "R5 no push on bypass", 32'(push_valid), 32'd0);
    @(negedge clk);
    check(byp_out == 18'h2BEEF, "R5 byp_out", 32'(byp_out), 32'h2BEEF);
    byp_in = 18'h1CAFE;
    do_read(3'b001);
    check(dout == 18'h1CAFE, "R5 read byp_in", 32'(dout), 32'h1CAFE);
  endtask

  task automatic test_reserved();
    do_write(3'b010, 18'h3FFFF);
    check(!push_valid, "R9 no push", 32'(push_valid), 32'd0);
    do_write(3'b011, 18'h00042);
    @(negedge clk);
    check(byp_out == 18'h2BEEF, "R9 bypass kept", 32'(byp_out), 32'h2BEEF);
    check(ofs_out_ae == 9'h005 && ofs_in_af == 9'h100, "R9 offsets kept",
          32'(ofs_out_ae), 32'h005);
    do_read(3'b011);
    check(dout == '0, "R9 read zero", 32'(dout), 32'd0);
  endtask

  task automatic test_cs_high();
    @(negedge clk);
    cs_n = 1'b1; rw = 1'b0; en_n = 1'b0; addr = 3'b101; din = 18'h000AA;
    @(negedge clk);
    addr = 3'b000;
    @(negedge clk);
    check(!push_valid, "R1 no push", 32'(push_valid), 32'd0);
    check(ofs_out_af == 9'h1F0, "R1 offset kept", 32'(ofs_out_af), 32'h1F0);
    rw = 1'b1; oe_n = 1'b0; pop_valid = 1'b1; pop_data = 18'h3A3A3;
    #1;
    check(!pop_ready, "R1 no pop", 32'(pop_ready), 32'd0);
    check(!drv_en, "R1 no drive", 32'(drv_en), 32'd0);
    @(negedge clk);
    check(dout == '0, "R1 dout kept", 32'(dout), 32'd0);
    idle();
    pop_valid = 1'b0;
  endtask

  task automatic test_enable_high();
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b0; en_n = 1'b1; addr = 3'b000; din = 18'h11111;
    @(negedge clk);
    check(!push_valid, "R11 no write", 32'(push_valid), 32'd0);
    rw = 1'b1; pop_valid = 1'b1; pop_data = 18'h22222;
    #1;
    check(!pop_ready, "R11 no pop", 32'(pop_ready), 32'd0);
    @(negedge clk);
    check(dout == '0, "R11 dout kept", 32'(dout), 32'd0);
    idle();
    pop_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fifo_write();
    test_full_drop();
    test_fifo_read();
    test_empty_read();
    test_offsets();
    test_bypass();
    test_reserved();
    test_cs_high();
    test_enable_high();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule